// File: doc/BRIEF.md
# Disc Controller Indexed Register Bank

This block is the host-facing register bank of an optical disc data controller. A host reaches a set of byte-wide registers through a 4-bit index. The index moves on by one after every read or write, so a host can set it once and then stream through a run of neighbouring registers. Writes set up the transfer byte count, the data address, the write address and the block pointer. They also carry the interface control bits, the two decoder control bytes, a transfer trigger, a transfer acknowledge and a soft reset. Reads return the interface status, the byte count, two banks of sector header bytes, the pointers and four status bytes.

The datapath and the sector decoder sit outside this block and drive it through strobes. `dec_valid` carries a freshly decoded header. `xfer_end` reports the end of a transfer. The block flags events in the active-low interface status byte and keeps one level-sensitive interrupt request. The request is set from the pending flags and their enable bits, and it is gated by an external enable.

When an index load and an access fall in the same cycle, the index load wins. When a write and a read fall in the same cycle, the read is ignored. When a strobe and a register access touch the same bit in the same cycle, the access decides.

Top module: `dctl_regbank`

## Requirements
- R1: Each read or write at a non-zero index N moves the index to (N+1) mod 16. An access at index 0 has no effect and leaves the index at 0. An `idx_wr` load overrides any access in that cycle.
- R2: After hardware reset the read map holds the following values: interface status 0xFF, byte count 0x0000, header 00 00 00 01, pointer 0x0000, write address 0x0000, status 0x00, 0x00, 0x00, 0x80. The index is 0, `irq` is 0 and `xfer_start` is 0.
- R3: A write to index 15 restores the following to their reset values: interface status, interface control, both decoder controls, status bytes and headers. It clears `irq` and leaves the index at 0. The byte count, data address, write address and block pointer are kept.
- R4: Interface status is active-low, with bit 6 for transfer end, bit 5 for decoder event, bit 3 for busy and bit 1 for data ready. A write to interface control (index 1) with bit 1 (output enable) clear forces bits 3 and 1 high.
- R5: A write to decoder control 0 (index 10) copies its bit 7 into status 0 bit 7. It loads status 2 with decoder control 1 bit 3 (into bit 3) and bit 2 (into bit 2). Bit 2 is forced to 0 when control 0 bit 4 (auto mode) is set. A write to decoder control 1 (index 11) reloads status 2 by the same rule.
- R6: A `dec_valid` strobe while control 0 bit 7 is set does four things. It moves the current header to the previous bank and captures `dec_header` (byte at index 4 = bits 31:24) as the current header. It clears status 3 and pulls status bit 5 low. Indexes 4 to 7 read the previous bank when control 1 bit 0 is set, and the current bank otherwise. With bit 7 clear the strobe does nothing.
- R7: Reading status 3 (index 15) returns its value. It then sets status 3 to 0x80, drives status bit 5 high and wraps the index to 0.
- R8: A write to interface control sets `irq` when `irq_en` is high and one of two conditions holds. Either data bit 6 is set and status bit 6 is low, or data bit 5 is set and status bit 5 is low. Otherwise the write clears `irq`.
- R9: A write to index 6 while output enable is set does three things. It pulls status bit 3 low, and also bit 1 when `dest_host` is high. It clears byte count bits 15:12. It pulses `xfer_start` for one cycle. With output enable clear it changes nothing.
- R10: An `xfer_end` strobe loads the byte count with 0xF000, pulls status bit 6 low and drives bits 3 and 1 high. A write to index 7 drives status bit 6 high and clears byte count bits 15:12.
- R11: A decoder capture with interface control bit 5 set, or an `xfer_end` with interface control bit 6 set, sets `irq` when `irq_en` is high.
- R12: Status 1 (index 13) always reads 0x00. Index 0 reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load the index from `idx_val` |
| idx_val | input | 4 | Index value to load |
| wr_en | input | 1 | Register write strobe at the current index |
| rd_en | input | 1 | Register read strobe at the current index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current index (combinational) |
| cur_index | output | 4 | Current index |
| dec_valid | input | 1 | Decoder header strobe |
| dec_header | input | 32 | Decoded header, byte 0 in bits 31:24 |
| xfer_end | input | 1 | Transfer-complete strobe from the datapath |
| dest_host | input | 1 | Transfer destination is the host read port |
| irq_en | input | 1 | External interrupt enable |
| byte_count | output | 16 | Transfer byte count |
| data_addr | output | 16 | Transfer data address |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| irq | output | 1 | Interrupt request level |

## Verification
A wrong index shows up on the very next access: the read comes from the wrong register, and every later byte of a streamed run is shifted. Bad pending flags or a bad interrupt enable show up on `irq` one edge after the interface control write or strobe that should have set or cleared it. The same fault is also visible in the interface status byte at the next read of index 1. A status 2 mode bit computed wrongly appears at the first read of index 14 after a control write. The bench therefore sweeps every combination of mode, form and auto bits, and reads status 2 back after both control 0 and control 1 writes.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  localparam int IDX_W = 4;
  localparam int DAT_W = 8;
  localparam int CNT_W = 2 * DAT_W;
  localparam int HDR_W = 4 * DAT_W;

  // write index map (order follows host streaming behaviour)
  localparam logic [IDX_W-1:0] WX_IFC  = 4'd1;
  localparam logic [IDX_W-1:0] WX_BCL  = 4'd2;
  localparam logic [IDX_W-1:0] WX_BCH  = 4'd3;
  localparam logic [IDX_W-1:0] WX_DAL  = 4'd4;
  localparam logic [IDX_W-1:0] WX_DAH  = 4'd5;
  localparam logic [IDX_W-1:0] WX_TRIG = 4'd6;
  localparam logic [IDX_W-1:0] WX_ACK  = 4'd7;
  localparam logic [IDX_W-1:0] WX_WAL  = 4'd8;
  localparam logic [IDX_W-1:0] WX_WAH  = 4'd9;
  localparam logic [IDX_W-1:0] WX_CT0  = 4'd10;
  localparam logic [IDX_W-1:0] WX_CT1  = 4'd11;
  localparam logic [IDX_W-1:0] WX_PTL  = 4'd12;
  localparam logic [IDX_W-1:0] WX_PTH  = 4'd13;
  localparam logic [IDX_W-1:0] WX_SRST = 4'd15;

  // read index map
  localparam logic [IDX_W-1:0] RX_IFST = 4'd1;
  localparam logic [IDX_W-1:0] RX_BCL  = 4'd2;
  localparam logic [IDX_W-1:0] RX_BCH  = 4'd3;
  localparam logic [IDX_W-1:0] RX_HD0  = 4'd4;
  localparam logic [IDX_W-1:0] RX_HD1  = 4'd5;
  localparam logic [IDX_W-1:0] RX_HD2  = 4'd6;
  localparam logic [IDX_W-1:0] RX_HD3  = 4'd7;
  localparam logic [IDX_W-1:0] RX_PTL  = 4'd8;
  localparam logic [IDX_W-1:0] RX_PTH  = 4'd9;
  localparam logic [IDX_W-1:0] RX_WAL  = 4'd10;
  localparam logic [IDX_W-1:0] RX_WAH  = 4'd11;
  localparam logic [IDX_W-1:0] RX_ST0  = 4'd12;
  localparam logic [IDX_W-1:0] RX_ST1  = 4'd13;
  localparam logic [IDX_W-1:0] RX_ST2  = 4'd14;
  localparam logic [IDX_W-1:0] RX_ST3  = 4'd15;

  // active-low interface status bits, and matching control bits
  localparam int B_END  = 6;
  localparam int B_DEC  = 5;
  localparam int B_BUSY = 3;
  localparam int B_RDY  = 1;
  localparam int B_OE   = 1;
  // decoder control bits
  localparam int B_DECON = 7;
  localparam int B_AUTO  = 4;
  localparam int B_MODE  = 3;
  localparam int B_FORM  = 2;
  localparam int B_HSEL  = 0;

  localparam logic [DAT_W-1:0] IFST_INIT = 8'hFF;
  localparam logic [DAT_W-1:0] ST3_INIT  = 8'h80;
  localparam logic [HDR_W-1:0] HDR_INIT  = 32'h0000_0001;
  localparam logic [CNT_W-1:0] CNT_DONE  = 16'hF000;

  function automatic logic [DAT_W-1:0] mode_status(input logic mode_b,
                                                   input logic form_b,
                                                   input logic auto_on);
    logic [DAT_W-1:0] v;
    v = '0;
    v[B_MODE] = mode_b;
    v[B_FORM] = form_b & ~auto_on;
    return v;
  endfunction
endpackage

// File: rtl/dctl_index.sv
module dctl_index
  import dctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             access,
  input  logic             soft_rst,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (load) begin
      idx_d  = load_val;
      idx_en = 1'b1;
    end else if (soft_rst) begin
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (access && (idx_q != '0)) begin
      idx_d  = idx_q + 1'b1;   // index 15 wraps to 0
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/dctl_core.sv
module dctl_core
  import dctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [IDX_W-1:0] idx,
  input  logic [DAT_W-1:0] wdata,
  input  logic             dec_valid,
  input  logic [HDR_W-1:0] dec_header,
  input  logic             xfer_end,
  input  logic             dest_host,
  output logic [DAT_W-1:0] ifst,
  output logic             ie_end,
  output logic             ie_dec,
  output logic [CNT_W-1:0] bc,
  output logic [CNT_W-1:0] da,
  output logic [CNT_W-1:0] wa,
  output logic [CNT_W-1:0] pt,
  output logic [DAT_W-1:0] st0,
  output logic [DAT_W-1:0] st2,
  output logic [DAT_W-1:0] st3,
  output logic [HDR_W-1:0] hcur,
  output logic [HDR_W-1:0] hprev,
  output logic             hsel,
  output logic             dec_take,
  output logic             start_pulse
);
  logic [DAT_W-1:0] ifst_q, ifst_d, st0_q, st0_d, st2_q, st2_d, st3_q, st3_d;
  logic             oe_q, oe_d, ie_end_q, ie_end_d, ie_dec_q, ie_dec_d;
  logic             decon_q, decon_d, auto_q, auto_d;
  logic             mode_q, mode_d, form_q, form_d, hsel_q, hsel_d;
  logic [CNT_W-1:0] bc_q, bc_d, da_q, da_d, wa_q, wa_d, pt_q, pt_d;
  logic [HDR_W-1:0] hcur_q, hcur_d, hprev_q, hprev_d;
  logic             start_q, start_d;

  assign dec_take = dec_valid & decon_q;

  always_comb begin
    ifst_d = ifst_q;  st0_d = st0_q;  st2_d = st2_q;  st3_d = st3_q;
    oe_d = oe_q;  ie_end_d = ie_end_q;  ie_dec_d = ie_dec_q;
    decon_d = decon_q;  auto_d = auto_q;
    mode_d = mode_q;  form_d = form_q;  hsel_d = hsel_q;
    bc_d = bc_q;  da_d = da_q;  wa_d = wa_q;  pt_d = pt_q;
    hcur_d = hcur_q;  hprev_d = hprev_q;
    start_d = 1'b0;

    // strobes from the decoder and the datapath
    if (dec_take) begin
      hprev_d       = hcur_q;
      hcur_d        = dec_header;
      st3_d         = '0;
      ifst_d[B_DEC] = 1'b0;
    end
    if (xfer_end) begin
      bc_d           = CNT_DONE;
      ifst_d[B_BUSY] = 1'b1;
      ifst_d[B_RDY]  = 1'b1;
      ifst_d[B_END]  = 1'b0;
    end

    // host accesses take priority over strobes
    if (wr) begin
      unique case (idx)
        WX_IFC: begin
          oe_d     = wdata[B_OE];
          ie_end_d = wdata[B_END];
          ie_dec_d = wdata[B_DEC];
          if (!wdata[B_OE]) begin
            ifst_d[B_BUSY] = 1'b1;
            ifst_d[B_RDY]  = 1'b1;
          end
        end
        WX_BCL: bc_d[DAT_W-1:0]     = wdata;
        WX_BCH: bc_d[CNT_W-1:DAT_W] = wdata;
        WX_DAL: da_d[DAT_W-1:0]     = wdata;
        WX_DAH: da_d[CNT_W-1:DAT_W] = wdata;
        WX_TRIG: begin
          if (oe_q) begin
            ifst_d[B_BUSY]         = 1'b0;
            if (dest_host) ifst_d[B_RDY] = 1'b0;
            bc_d[CNT_W-1:CNT_W-4]  = '0;
            start_d                = 1'b1;
          end
        end
        WX_ACK: begin
          ifst_d[B_END]         = 1'b1;
          bc_d[CNT_W-1:CNT_W-4] = '0;
        end
        WX_WAL: wa_d[DAT_W-1:0]     = wdata;
        WX_WAH: wa_d[CNT_W-1:DAT_W] = wdata;
        WX_CT0: begin
          decon_d = wdata[B_DECON];
          auto_d  = wdata[B_AUTO];
          st0_d   = '0;
          st0_d[B_DECON] = wdata[B_DECON];
          st2_d   = mode_status(mode_q, form_q, wdata[B_AUTO]);
        end
        WX_CT1: begin
          mode_d = wdata[B_MODE];
          form_d = wdata[B_FORM];
          hsel_d = wdata[B_HSEL];
          st2_d  = mode_status(wdata[B_MODE], wdata[B_FORM], auto_q);
        end
        WX_PTL: pt_d[DAT_W-1:0]     = wdata;
        WX_PTH: pt_d[CNT_W-1:DAT_W] = wdata;
        WX_SRST: begin
          ifst_d = IFST_INIT;  oe_d = 1'b0;  ie_end_d = 1'b0;  ie_dec_d = 1'b0;
          decon_d = 1'b0;  auto_d = 1'b0;  mode_d = 1'b0;  form_d = 1'b0;
          hsel_d = 1'b0;  st0_d = '0;  st2_d = '0;  st3_d = ST3_INIT;
          hcur_d = HDR_INIT;  hprev_d = '0;
        end
        default: ;
      endcase
    end else if (rd && (idx == RX_ST3)) begin
      st3_d         = ST3_INIT;
      ifst_d[B_DEC] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifst_q <= IFST_INIT;  st0_q <= '0;  st2_q <= '0;  st3_q <= ST3_INIT;
      oe_q <= 1'b0;  ie_end_q <= 1'b0;  ie_dec_q <= 1'b0;
      decon_q <= 1'b0;  auto_q <= 1'b0;  mode_q <= 1'b0;  form_q <= 1'b0;
      hsel_q <= 1'b0;
      bc_q <= '0;  da_q <= '0;  wa_q <= '0;  pt_q <= '0;
      hcur_q <= HDR_INIT;  hprev_q <= '0;
      start_q <= 1'b0;
    end else begin
      ifst_q <= ifst_d;  st0_q <= st0_d;  st2_q <= st2_d;  st3_q <= st3_d;
      oe_q <= oe_d;  ie_end_q <= ie_end_d;  ie_dec_q <= ie_dec_d;
      decon_q <= decon_d;  auto_q <= auto_d;  mode_q <= mode_d;  form_q <= form_d;
      hsel_q <= hsel_d;
      bc_q <= bc_d;  da_q <= da_d;  wa_q <= wa_d;  pt_q <= pt_d;
      hcur_q <= hcur_d;  hprev_q <= hprev_d;
      start_q <= start_d;
    end
  end

  assign ifst = ifst_q;  assign ie_end = ie_end_q;  assign ie_dec = ie_dec_q;
  assign bc = bc_q;  assign da = da_q;  assign wa = wa_q;  assign pt = pt_q;
  assign st0 = st0_q;  assign st2 = st2_q;  assign st3 = st3_q;
  assign hcur = hcur_q;  assign hprev = hprev_q;  assign hsel = hsel_q;
  assign start_pulse = start_q;
endmodule

// File: rtl/dctl_irq.sv
module dctl_irq
  import dctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ifc_wr,
  input  logic wd_end,
  input  logic wd_dec,
  input  logic end_n,
  input  logic dec_n,
  input  logic ie_end,
  input  logic ie_dec,
  input  logic dec_take,
  input  logic xfer_end,
  input  logic irq_en,
  input  logic soft_rst,
  output logic irq
);
  logic irq_q, irq_d, pend_now, event_set;

  assign pend_now  = (wd_end & ~end_n) | (wd_dec & ~dec_n);
  assign event_set = ((dec_take & ie_dec) | (xfer_end & ie_end)) & irq_en;

  always_comb begin
    irq_d = irq_q;
    if (soft_rst)       irq_d = 1'b0;
    else if (ifc_wr)    irq_d = pend_now & irq_en;
    else if (event_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/dctl_rdmux.sv
module dctl_rdmux
  import dctl_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [DAT_W-1:0] ifst,
  input  logic [CNT_W-1:0] bc,
  input  logic [CNT_W-1:0] wa,
  input  logic [CNT_W-1:0] pt,
  input  logic [DAT_W-1:0] st0,
  input  logic [DAT_W-1:0] st2,
  input  logic [DAT_W-1:0] st3,
  input  logic [HDR_W-1:0] hcur,
  input  logic [HDR_W-1:0] hprev,
  input  logic             hsel,
  output logic [DAT_W-1:0] rdata
);
  localparam int NHB = HDR_W / DAT_W;
  logic [HDR_W-1:0] hsrc;
  logic [DAT_W-1:0] hbyte [NHB];

  assign hsrc = hsel ? hprev : hcur;

  for (genvar k = 0; k < NHB; k++) begin : g_hbyte
    assign hbyte[k] = hsrc[HDR_W-1-k*DAT_W -: DAT_W];
  end

  always_comb begin
    unique case (idx)
      RX_IFST: rdata = ifst;
      RX_BCL:  rdata = bc[DAT_W-1:0];
      RX_BCH:  rdata = bc[CNT_W-1:DAT_W];
      RX_HD0:  rdata = hbyte[0];
      RX_HD1:  rdata = hbyte[1];
      RX_HD2:  rdata = hbyte[2];
      RX_HD3:  rdata = hbyte[3];
      RX_PTL:  rdata = pt[DAT_W-1:0];
      RX_PTH:  rdata = pt[CNT_W-1:DAT_W];
      RX_WAL:  rdata = wa[DAT_W-1:0];
      RX_WAH:  rdata = wa[CNT_W-1:DAT_W];
      RX_ST0:  rdata = st0;
      RX_ST1:  rdata = '0;
      RX_ST2:  rdata = st2;
      RX_ST3:  rdata = st3;
      default: rdata = '1;
    endcase
  end
endmodule

// File: rtl/dctl_regbank.sv
module dctl_regbank
  import dctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_wr,
  input  logic [3:0]  idx_val,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic [3:0]  cur_index,
  input  logic        dec_valid,
  input  logic [31:0] dec_header,
  input  logic        xfer_end,
  input  logic        dest_host,
  input  logic        irq_en,
  output logic [15:0] byte_count,
  output logic [15:0] data_addr,
  output logic        xfer_start,
  output logic        irq
);
  logic             acc_wr, acc_rd, soft_rst, ifc_wr;
  logic [IDX_W-1:0] idx;
  logic [DAT_W-1:0] ifst, st0, st2, st3;
  logic [CNT_W-1:0] bc, da, wa, pt;
  logic [HDR_W-1:0] hcur, hprev;
  logic             ie_end, ie_dec, hsel, dec_take, start_pulse;

  assign acc_wr   = wr_en & ~idx_wr;
  assign acc_rd   = rd_en & ~wr_en & ~idx_wr;
  assign soft_rst = acc_wr & (idx == WX_SRST);
  assign ifc_wr   = acc_wr & (idx == WX_IFC);

  dctl_index u_index (
    .clk(clk), .rst_n(rst_n), .load(idx_wr), .load_val(idx_val),
    .access(acc_wr | acc_rd), .soft_rst(soft_rst), .idx(idx)
  );

  dctl_core u_core (
    .clk(clk), .rst_n(rst_n), .wr(acc_wr), .rd(acc_rd), .idx(idx),
    .wdata(wr_data), .dec_valid(dec_valid), .dec_header(dec_header),
    .xfer_end(xfer_end), .dest_host(dest_host),
    .ifst(ifst), .ie_end(ie_end), .ie_dec(ie_dec),
    .bc(bc), .da(da), .wa(wa), .pt(pt),
    .st0(st0), .st2(st2), .st3(st3), .hcur(hcur), .hprev(hprev),
    .hsel(hsel), .dec_take(dec_take), .start_pulse(start_pulse)
  );

  dctl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ifc_wr(ifc_wr),
    .wd_end(wr_data[B_END]), .wd_dec(wr_data[B_DEC]),
    .end_n(ifst[B_END]), .dec_n(ifst[B_DEC]),
    .ie_end(ie_end), .ie_dec(ie_dec), .dec_take(dec_take),
    .xfer_end(xfer_end), .irq_en(irq_en), .soft_rst(soft_rst), .irq(irq)
  );

  dctl_rdmux u_rdmux (
    .idx(idx), .ifst(ifst), .bc(bc), .wa(wa), .pt(pt),
    .st0(st0), .st2(st2), .st3(st3), .hcur(hcur), .hprev(hprev),
    .hsel(hsel), .rdata(rd_data)
  );

  assign cur_index  = idx;
  assign byte_count = bc;
  assign data_addr  = da;
  assign xfer_start = start_pulse;
endmodule

// File: rtl/dctl_regbank_chk.sv
module dctl_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        idx_wr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  cur_index,
  input logic        xfer_end,
  input logic        irq_en,
  input logic [15:0] byte_count,
  input logic        xfer_start,
  input logic        irq
);
  // R1: an access at a non-zero index steps the index by one
  a_r1_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && (wr_en || rd_en) && cur_index != 4'd0)
      |=> cur_index == 4'($past(cur_index) + 4'd1));

  // R1: with no access and no load the index holds
  a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !wr_en && !rd_en) |=> $stable(cur_index));

  // R10: the end strobe loads the done count unless a write lands
  a_r10_end_count: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !(wr_en && !idx_wr)) |=> byte_count == 16'hF000);

  // R10: acknowledge clears the top nibble of the count
  a_r10_ack_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idx_wr && cur_index == 4'd7 && !xfer_end)
      |=> byte_count[15:12] == 4'd0);

  // R9: a start pulse only follows a trigger write
  a_r9_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(wr_en && !idx_wr && cur_index == 4'd6));

  // R8: the request only rises while the external enable was high
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));

  // R8 / R3: the request only falls on a control write or soft reset
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && !idx_wr &&
                         (cur_index == 4'd1 || cur_index == 4'd15)));
endmodule

bind dctl_regbank dctl_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wr_en(wr_en), .rd_en(rd_en),
  .cur_index(cur_index), .xfer_end(xfer_end), .irq_en(irq_en),
  .byte_count(byte_count), .xfer_start(xfer_start), .irq(irq)
);

// File: tb/dctl_regbank_test.sv
module dctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  idx_val = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [3:0]  cur_index;
  logic        dec_valid = 1'b0, xfer_end = 1'b0, dest_host = 1'b0, irq_en = 1'b1;
  logic [31:0] dec_header = '0;
  logic [15:0] byte_count, data_addr;
  logic        xfer_start, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .cur_index(cur_index), .dec_valid(dec_valid), .dec_header(dec_header),
    .xfer_end(xfer_end), .dest_host(dest_host), .irq_en(irq_en),
    .byte_count(byte_count), .data_addr(data_addr),
    .xfer_start(xfer_start), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic seti(input logic [3:0] n);
    @(negedge clk); idx_wr = 1'b1; idx_val = n;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] n, input logic [7:0] d);
    seti(n); wr(d);
  endtask

  task automatic rreg(input logic [3:0] n, output logic [7:0] d);
    seti(n); rd(d);
  endtask

  task automatic dec(input logic [31:0] h);
    @(negedge clk); dec_valid = 1'b1; dec_header = h;
    @(negedge clk); dec_valid = 1'b0;
  endtask

  task automatic xend();
    @(negedge clk); xfer_end = 1'b1;
    @(negedge clk); xfer_end = 1'b0;
  endtask

  // stream indexes 1..15 and compare against 15 expected bytes
  task automatic sweep_map(input string req, input logic [119:0] exp);
    logic [7:0] v;
    seti(4'd1);
    for (int i = 0; i < 15; i++) begin
      rd(v);
      check(req, {24'd0, v}, {24'd0, exp[119 - 8*i -: 8]});
    end
    check({req, " wrap"}, {28'd0, cur_index}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 index", {28'd0, cur_index}, 32'd0);
    check("R2 irq", {31'd0, irq}, 32'd0);
    check("R2 start", {31'd0, xfer_start}, 32'd0);
    check("R2 count", {16'd0, byte_count}, 32'd0);
    sweep_map("R2 R7 map", 120'hFF_0000_00000001_0000_0000_000000_80);

    // R12 index 0 reads FF; R1 access at index 0 keeps index 0
    rd(v);
    check("R12 idx0 read", {24'd0, v}, 32'hFF);
    check("R1 idx0 hold", {28'd0, cur_index}, 32'd0);

    // R1 streamed writes
    seti(4'd2); wr(8'h34); wr(8'h12); wr(8'h78); wr(8'h56);
    check("R1 count", {16'd0, byte_count}, 32'h1234);
    check("R1 addr", {16'd0, data_addr}, 32'h5678);
    check("R1 index", {28'd0, cur_index}, 32'd6);
    seti(4'd8); wr(8'hAB); wr(8'hCD);
    seti(4'd12); wr(8'hEF); wr(8'h01);
    seti(4'd8);
    rd(v); check("R1 ptl", {24'd0, v}, 32'hEF);
    rd(v); check("R1 pth", {24'd0, v}, 32'h01);
    rd(v); check("R1 wal", {24'd0, v}, 32'hAB);
    rd(v); check("R1 wah", {24'd0, v}, 32'hCD);

    // R5 exhaustive mode/form/auto/decode sweep
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 2; a++) begin
        for (int e = 0; e < 2; e++) begin
          logic [7:0] c1, c1b, ex2;
          c1 = {4'(c), 4'(c)};
          wreg(4'd11, c1);
          seti(4'd10); wr({e[0], 2'b00, a[0], 4'b0000});
          ex2 = {4'd0, c1[3], c1[2] & ~a[0], 2'b00};
          seti(4'd12);
          rd(v); check("R5 st0", {24'd0, v}, {24'd0, e[0], 7'd0});
          rd(v); check("R12 st1", {24'd0, v}, 32'd0);
          rd(v); check("R5 st2 ct0", {24'd0, v}, {24'd0, ex2});
          c1b = c1 ^ 8'h0C;
          wreg(4'd11, c1b);
          ex2 = {4'd0, c1b[3], c1b[2] & ~a[0], 2'b00};
          rreg(4'd14, v); check("R5 st2 ct1", {24'd0, v}, {24'd0, ex2});
        end
      end
    end
    wreg(4'd11, 8'h00);
    wreg(4'd10, 8'h80);

    // R6 header capture and bank select
    dec(32'hA1B2C3D4);
    dec(32'h11223344);
    rreg(4'd1, v); check("R6 ifst dec low", {24'd0, v}, 32'hDF);
    seti(4'd4);
    for (int i = 0; i < 4; i++) begin
      rd(v); check("R6 cur hdr", {24'd0, v}, {24'd0, 8'h11 * 8'(i + 1)});
    end
    wreg(4'd11, 8'h01);
    seti(4'd4);
    rd(v); check("R6 prev hdr0", {24'd0, v}, 32'hA1);
    rd(v); check("R6 prev hdr1", {24'd0, v}, 32'hB2);
    rd(v); check("R6 prev hdr2", {24'd0, v}, 32'hC3);
    rd(v); check("R6 prev hdr3", {24'd0, v}, 32'hD4);
    wreg(4'd11, 8'h00);
    wreg(4'd10, 8'h00);
    dec(32'hDEADBEEF);
    rreg(4'd4, v); check("R6 disabled hdr", {24'd0, v}, 32'h11);

    // R7 status 3 read side effects
    rreg(4'd15, v); check("R7 st3 first", {24'd0, v}, 32'h00);
    check("R7 wrap", {28'd0, cur_index}, 32'd0);
    rreg(4'd1, v); check("R7 ifst dec high", {24'd0, v}, 32'hFF);
    rreg(4'd15, v); check("R7 st3 second", {24'd0, v}, 32'h80);

    // R8 / R11 interrupt request
    wreg(4'd10, 8'h80);
    wreg(4'd1, 8'h22);
    check("R8 none pending", {31'd0, irq}, 32'd0);
    dec(32'h0A0B0C0D);
    check("R11 dec irq", {31'd0, irq}, 32'd1);
    wreg(4'd1, 8'h02);
    check("R8 clear", {31'd0, irq}, 32'd0);
    wreg(4'd1, 8'h22);
    check("R8 pending set", {31'd0, irq}, 32'd1);
    irq_en = 1'b0;
    wreg(4'd1, 8'h22);
    check("R8 gated", {31'd0, irq}, 32'd0);
    irq_en = 1'b1;
    rreg(4'd15, v);
    wreg(4'd1, 8'h22);
    check("R8 flag cleared", {31'd0, irq}, 32'd0);

    // R9 trigger with output enabled, host destination
    dest_host = 1'b1;
    wreg(4'd2, 8'h10); wr(8'hF0);
    seti(4'd6); wr(8'h00);
    check("R9 start pulse", {31'd0, xfer_start}, 32'd1);
    check("R9 nibble", {16'd0, byte_count}, 32'h0010);
    @(negedge clk);
    check("R9 pulse width", {31'd0, xfer_start}, 32'd0);
    rreg(4'd1, v); check("R9 ifst host", {24'd0, v}, 32'hF5);

    // R4 output disable aborts
    wreg(4'd1, 8'h40);
    check("R4 no irq", {31'd0, irq}, 32'd0);
    rreg(4'd1, v); check("R4 abort", {24'd0, v}, 32'hFF);
    // R9 trigger ignored with output disabled
    wreg(4'd2, 8'h10); wr(8'hF0);
    seti(4'd6); wr(8'h00);
    check("R9 no start", {31'd0, xfer_start}, 32'd0);
    check("R9 count kept", {16'd0, byte_count}, 32'hF010);
    rreg(4'd1, v); check("R9 ifst kept", {24'd0, v}, 32'hFF);

    // R10 / R11 transfer end and acknowledge
    wreg(4'd1, 8'h42);
    dest_host = 1'b0;
    seti(4'd6); wr(8'h00);
    check("R9 start dma", {31'd0, xfer_start}, 32'd1);
    rreg(4'd1, v); check("R9 ifst busy", {24'd0, v}, 32'hF7);
    xend();
    check("R10 end count", {16'd0, byte_count}, 32'hF000);
    check("R11 end irq", {31'd0, irq}, 32'd1);
    rreg(4'd1, v); check("R10 ifst end", {24'd0, v}, 32'hBF);
    seti(4'd7); wr(8'h00);
    check("R10 ack count", {16'd0, byte_count}, 32'h0000);
    rreg(4'd1, v); check("R10 ack flag", {24'd0, v}, 32'hFF);
    check("R10 irq held", {31'd0, irq}, 32'd1);
    wreg(4'd1, 8'h02);
    check("R8 clear end", {31'd0, irq}, 32'd0);

    // R3 soft reset
    wreg(4'd2, 8'h34); wr(8'h12);
    wreg(4'd11, 8'h0D);
    wreg(4'd10, 8'h90);
    wreg(4'd1, 8'h22);
    dec(32'h55667788);
    check("R3 irq before", {31'd0, irq}, 32'd1);
    seti(4'd15); wr(8'h00);
    check("R3 index", {28'd0, cur_index}, 32'd0);
    check("R3 irq", {31'd0, irq}, 32'd0);
    check("R3 addr kept", {16'd0, data_addr}, 32'h5678);
    sweep_map("R3 map", 120'hFF_3412_00000001_EF01_ABCD_000000_80);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule